// File: doc/BRIEF.md
# Packet-Filter VM Branch Resolution Unit

This block resolves control-flow instructions for a 64-bit packet-filter virtual machine. On each issue strobe it takes the 8-bit opcode, the destination and source register values, the 32-bit immediate, the 16-bit signed offset and the current program counter. One cycle later it presents the next program counter, a taken flag, and one-cycle call, exit and illegal indications for the sequencer that owns the call stack and helper dispatch.

A single comparator lane per width evaluates equality, unsigned order, signed order and a bit-test condition. The lanes run at 64 bits for one instruction class and at the low 32 bits for the other. A two-state controller (`S_IDLE`, `S_RESULT`) frames each result. `S_IDLE` moves to `S_RESULT` on an issue strobe. `S_RESULT` stays in `S_RESULT` on a back-to-back issue and returns to `S_IDLE` otherwise. The program counter counts 8-byte instruction slots.

Top module: `bvm_branch_unit`

## Requirements
- R1: After reset `res_valid`, `taken`, `call_pulse`, `exit_pulse` and `illegal` are 0 and `next_pc` is 0.
- R2: Each cycle with `issue_valid` high yields exactly one cycle of `res_valid` high on the following cycle, back-to-back issues give back-to-back results, and `res_valid` is 0 in any cycle that follows a cycle without an issue.
- R3: Opcode bits [2:0] select the class: 5 compares the full 64-bit operands and 6 compares only bits [31:0], ignoring the upper halves.
- R4: Opcode bit 3 selects the second operand: 1 takes `src_val`, and 0 takes `imm` sign-extended to 64 bits (with `src_val` ignored).
- R5: Operation code bits [7:4]: 0x1 is taken when equal, 0x5 when not equal, and 0x4 when the bitwise AND of the operands is nonzero.
- R6: Unsigned orderings: 0x2 is taken when dst > operand, 0x3 when >=, 0xa when <, and 0xb when <=.
- R7: Signed (two's complement) orderings: 0x6 is taken when dst > operand, 0x7 when >=, 0xc when <, and 0xd when <=.
- R8: A taken result gives `next_pc` = pc + 1 + sign-extended offset, modulo 2^PC_W. Every other result gives `next_pc` = pc + 1, modulo 2^PC_W.
- R9: Code 0x0 in class 5 is always taken, whatever the operands are.
- R10: Code 0x8 (either class) raises `call_pulse`, and code 0x9 in class 5 raises `exit_pulse`. Both leave `taken` at 0.
- R11: Codes 0x0 and 0x9 in class 6, codes 0xe and 0xf, and any class other than 5 or 6 all raise `illegal`. They leave `taken`, `call_pulse` and `exit_pulse` at 0.
- R12: At most one of `taken`, `call_pulse`, `exit_pulse` and `illegal` is high in any cycle, and none of them is high while `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| opcode | input | 8 | Operation code, operand select, class |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate operand |
| offset | input | 16 | Signed branch displacement in slots |
| pc | input | PC_W (32) | Current instruction slot index |
| res_valid | output | 1 | Result present this cycle |
| next_pc | output | PC_W (32) | Following instruction slot index |
| taken | output | 1 | Branch taken |
| call_pulse | output | 1 | Call request pulse |
| exit_pulse | output | 1 | Exit request pulse |
| illegal | output | 1 | Illegal encoding pulse |

## Verification
The compare is driven with operands that match in the low half but differ in the upper half, and each such pair is issued in both classes, which exposes any wrong lane width. All-ones values and values with only bit 31 set are each run through the unsigned and the signed codes, so that signed and unsigned orderings must disagree on the same data. Immediate-operand cases pair a negative immediate with a garbage source register, which separates a sign-extended immediate from a zero-extended one and from the register path. Negative offsets and wraparound program counters check the target arithmetic, and the cases for illegal encodings, call and exit check that these flags stay exclusive.

// File: rtl/bvm_pkg.sv
package bvm_pkg;

    typedef enum logic [3:0] {
        OP_JA   = 4'h0,
        OP_JEQ  = 4'h1,
        OP_JGT  = 4'h2,
        OP_JGE  = 4'h3,
        OP_JSET = 4'h4,
        OP_JNE  = 4'h5,
        OP_JSGT = 4'h6,
        OP_JSGE = 4'h7,
        OP_CALL = 4'h8,
        OP_EXIT = 4'h9,
        OP_JLT  = 4'ha,
        OP_JLE  = 4'hb,
        OP_JSLT = 4'hc,
        OP_JSLE = 4'hd,
        OP_RSVE = 4'he,
        OP_RSVF = 4'hf
    } br_op_e;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    typedef struct packed {
        br_op_e op;
        logic   is_cond;
        logic   is_ja;
        logic   is_call;
        logic   is_exit;
        logic   bad;
        logic   narrow;
        logic   use_reg;
    } br_dec_t;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_RESULT = 1'b1
    } br_state_e;

endpackage

// File: rtl/bvm_br_decode.sv
module bvm_br_decode
    import bvm_pkg::*;
(
    input  logic [7:0] opcode_i,
    output br_dec_t    dec_o
);
    logic [2:0] cls;
    logic       cls_ok;

    always_comb begin
        cls            = opcode_i[2:0];
        cls_ok         = (cls == CLS_WIDE) || (cls == CLS_NARROW);
        dec_o          = '0;
        dec_o.op       = br_op_e'(opcode_i[7:4]);
        dec_o.use_reg  = opcode_i[3];
        dec_o.narrow   = (cls == CLS_NARROW);
        unique case (br_op_e'(opcode_i[7:4]))
            OP_JA: begin
                dec_o.is_ja = (cls == CLS_WIDE);
                dec_o.bad   = (cls != CLS_WIDE);
            end
            OP_EXIT: begin
                dec_o.is_exit = (cls == CLS_WIDE);
                dec_o.bad     = (cls != CLS_WIDE);
            end
            OP_CALL: begin
                dec_o.is_call = cls_ok;
                dec_o.bad     = !cls_ok;
            end
            OP_RSVE, OP_RSVF: begin
                dec_o.bad = 1'b1;
            end
            default: begin
                dec_o.is_cond = cls_ok;
                dec_o.bad     = !cls_ok;
            end
        endcase
    end
endmodule

// File: rtl/bvm_cond_eval.sv
module bvm_cond_eval
    import bvm_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  br_op_e            op_i,
    input  logic              narrow_i,
    input  logic [XLEN-1:0]   lhs_i,
    input  logic [XLEN-1:0]   rhs_i,
    output logic              hit_o
);
    localparam int NLANE = 2;

    logic [NLANE-1:0] eq_v, ult_v, slt_v, any_v;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int W = (g == 0) ? XLEN : HALF;
        logic [W-1:0] a, b;
        assign a        = lhs_i[W-1:0];
        assign b        = rhs_i[W-1:0];
        assign eq_v[g]  = (a == b);
        assign ult_v[g] = (a < b);
        assign slt_v[g] = ($signed(a) < $signed(b));
        assign any_v[g] = |(a & b);
    end

    logic eq, ult, slt, any_set;
    always_comb begin
        eq      = narrow_i ? eq_v[1]  : eq_v[0];
        ult     = narrow_i ? ult_v[1] : ult_v[0];
        slt     = narrow_i ? slt_v[1] : slt_v[0];
        any_set = narrow_i ? any_v[1] : any_v[0];
    end

    always_comb begin
        unique case (op_i)
            OP_JEQ:  hit_o = eq;
            OP_JNE:  hit_o = !eq;
            OP_JSET: hit_o = any_set;
            OP_JGT:  hit_o = !ult && !eq;
            OP_JGE:  hit_o = !ult;
            OP_JLT:  hit_o = ult;
            OP_JLE:  hit_o = ult || eq;
            OP_JSGT: hit_o = !slt && !eq;
            OP_JSGE: hit_o = !slt;
            OP_JSLT: hit_o = slt;
            OP_JSLE: hit_o = slt || eq;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bvm_pc_next.sv
module bvm_pc_next #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             take_i,
    output logic [PC_W-1:0]  pc_o
);
    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] seq_pc;

    if (PC_W > OFF_W) begin : g_ext
        assign off_ext = {{(PC_W-OFF_W){off_i[OFF_W-1]}}, off_i};
    end else begin : g_trunc
        assign off_ext = off_i[PC_W-1:0];
    end

    assign seq_pc = pc_i + PC_W'(1);
    assign pc_o   = take_i ? (seq_pc + off_ext) : seq_pc;
endmodule

// File: rtl/bvm_branch_unit.sv
module bvm_branch_unit
    import bvm_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int HALF  = 32,
    parameter int IMM_W = 32,
    parameter int OFF_W = 16,
    parameter int PC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [7:0]        opcode,
    input  logic [XLEN-1:0]   dst_val,
    input  logic [XLEN-1:0]   src_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PC_W-1:0]   pc,
    output logic              res_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic              call_pulse,
    output logic              exit_pulse,
    output logic              illegal
);
    localparam int IMM_PAD = XLEN - IMM_W;

    br_dec_t         dec;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rhs;
    logic            cond_hit;
    logic            take_c;
    logic [PC_W-1:0] pc_c;
    br_state_e       state, state_nx;

    bvm_br_decode u_dec (
        .opcode_i (opcode),
        .dec_o    (dec)
    );

    assign imm_ext = {{IMM_PAD{imm[IMM_W-1]}}, imm};
    assign rhs     = dec.use_reg ? src_val : imm_ext;

    bvm_cond_eval #(.XLEN(XLEN), .HALF(HALF)) u_cmp (
        .op_i     (dec.op),
        .narrow_i (dec.narrow),
        .lhs_i    (dst_val),
        .rhs_i    (rhs),
        .hit_o    (cond_hit)
    );

    assign take_c = !dec.bad && (dec.is_ja || (dec.is_cond && cond_hit));

    bvm_pc_next #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
        .pc_i   (pc),
        .off_i  (offset),
        .take_i (take_c),
        .pc_o   (pc_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            S_IDLE:   state_nx = issue_valid ? S_RESULT : S_IDLE;
            S_RESULT: state_nx = issue_valid ? S_RESULT : S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    assign res_valid = (state == S_RESULT);

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc    <= '0;
            taken      <= 1'b0;
            call_pulse <= 1'b0;
            exit_pulse <= 1'b0;
            illegal    <= 1'b0;
        end else if (issue_valid) begin
            next_pc    <= pc_c;
            taken      <= take_c;
            call_pulse <= dec.is_call && !dec.bad;
            exit_pulse <= dec.is_exit && !dec.bad;
            illegal    <= dec.bad;
        end else begin
            taken      <= 1'b0;
            call_pulse <= 1'b0;
            exit_pulse <= 1'b0;
            illegal    <= 1'b0;
        end
    end

    // R2: result framing follows the issue strobe by one cycle
    a_r2_issue_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> res_valid);
    a_r2_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !res_valid);

    // R12: flags exclusive and only within a result
    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken, call_pulse, exit_pulse, illegal}));
    a_r12_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(taken || call_pulse || exit_pulse || illegal));

    // R8: a result that is not taken advances by one slot
    a_r8_sequential_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !taken) |-> (next_pc == PC_W'($past(pc) + 1'b1)));

    // R9: unconditional jump in the wide class
    a_r9_ja_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode[7:4] == 4'h0 && opcode[2:0] == CLS_WIDE) |=> taken);

    // R11: narrow-class jump/exit are illegal
    a_r11_narrow_ja_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode[2:0] == CLS_NARROW &&
         (opcode[7:4] == 4'h0 || opcode[7:4] == 4'h9)) |=> illegal);

    // R10: call request pulse
    a_r10_call_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode[7:4] == 4'h8 && opcode[2:0] == CLS_WIDE) |=> (call_pulse && !taken));
endmodule

// File: tb/bvm_branch_unit_tb.sv
`timescale 1ns/1ps
module bvm_branch_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] dst_val = '0, src_val = '0;
    logic [31:0] imm = '0;
    logic [15:0] offset = '0;
    logic [31:0] pc = '0;
    logic        res_valid, taken, call_pulse, exit_pulse, illegal;
    logic [31:0] next_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bvm_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset), .pc(pc),
        .res_valid(res_valid), .next_pc(next_pc), .taken(taken),
        .call_pulse(call_pulse), .exit_pulse(exit_pulse), .illegal(illegal)
    );

    function automatic logic [7:0] mk(input logic [3:0] code, input logic x, input logic [2:0] cls);
        return {code, x, cls};
    endfunction

    task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual {valid,t,c,x,i,pc}=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] im, input logic [15:0] off, input logic [31:0] p,
                       input bit et, input bit ec, input bit ex, input bit ei);
        logic [31:0] epc;
        @(negedge clk);
        opcode = op; dst_val = d; src_val = s; imm = im; offset = off; pc = p;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        epc = et ? (p + 32'd1 + {{16{off[15]}}, off}) : (p + 32'd1);
        check(tag, {res_valid, taken, call_pulse, exit_pulse, illegal, next_pc},
                   {1'b1, et, ec, ex, ei, epc});
    endtask

    task automatic t_reset();
        check("R1 reset", {res_valid, taken, call_pulse, exit_pulse, illegal, next_pc}, 37'd0);
    endtask

    task automatic t_equality();
        run("R5 eq64 taken", mk(4'h1,1,5), 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 0, 16'd5, 32'd100, 1,0,0,0);
        run("R3 eq64 upper differ", mk(4'h1,1,5), 64'h1111_0000_0000_0007, 64'h2222_0000_0000_0007, 0, 16'd5, 32'd100, 0,0,0,0);
        run("R3 eq32 upper ignored", mk(4'h1,1,6), 64'h1111_0000_0000_0007, 64'h2222_0000_0000_0007, 0, 16'd5, 32'd100, 1,0,0,0);
        run("R5 ne taken", mk(4'h5,1,5), 64'd3, 64'd4, 0, 16'd2, 32'd40, 1,0,0,0);
        run("R5 set none", mk(4'h4,1,5), 64'hF0, 64'h0F, 0, 16'd2, 32'd40, 0,0,0,0);
        run("R5 set hit", mk(4'h4,1,5), 64'h100, 64'h1FF, 0, 16'd2, 32'd40, 1,0,0,0);
        run("R3 set32 upper ignored", mk(4'h4,1,6), 64'h100_0000_0000, 64'h100_0000_0000, 0, 16'd2, 32'd40, 0,0,0,0);
    endtask

    task automatic t_operand_select();
        run("R4 imm sign-extended", mk(4'h1,0,5), 64'hFFFF_FFFF_FFFF_FFFF, 64'h5, 32'hFFFF_FFFF, 16'd3, 32'd7, 1,0,0,0);
        run("R4 imm not zero-extended", mk(4'h1,0,5), 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 32'hFFFF_FFFF, 16'd3, 32'd7, 0,0,0,0);
        run("R4 reg path ignores imm", mk(4'h1,1,5), 64'd9, 64'd9, 32'd1, 16'd3, 32'd7, 1,0,0,0);
    endtask

    task automatic t_unsigned();
        run("R6 gt unsigned", mk(4'h2,1,5), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 16'd1, 32'd0, 1,0,0,0);
        run("R6 ge equal", mk(4'h3,1,5), 64'd8, 64'd8, 0, 16'd1, 32'd0, 1,0,0,0);
        run("R6 lt", mk(4'ha,1,5), 64'd1, 64'd2, 0, 16'd1, 32'd0, 1,0,0,0);
        run("R6 le false", mk(4'hb,1,5), 64'd3, 64'd2, 0, 16'd1, 32'd0, 0,0,0,0);
    endtask

    task automatic t_signed();
        run("R7 sgt neg vs 1", mk(4'h6,1,5), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 16'd1, 32'd0, 0,0,0,0);
        run("R7 slt -1 < 0", mk(4'hc,1,5), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 16'd1, 32'd0, 1,0,0,0);
        run("R7 sge32 bit31 negative", mk(4'h7,1,6), 64'h8000_0000, 64'd0, 0, 16'd1, 32'd0, 0,0,0,0);
        run("R7 sge64 bit31 positive", mk(4'h7,1,5), 64'h8000_0000, 64'd0, 0, 16'd1, 32'd0, 1,0,0,0);
        run("R7 sle equal", mk(4'hd,1,5), 64'd5, 64'd5, 0, 16'd1, 32'd0, 1,0,0,0);
    endtask

    task automatic t_target();
        run("R8 negative offset", mk(4'h1,1,5), 64'd0, 64'd0, 0, 16'hFFFD, 32'd10, 1,0,0,0);
        run("R8 offset -1 self", mk(4'h1,1,5), 64'd0, 64'd0, 0, 16'hFFFF, 32'd0, 1,0,0,0);
        run("R8 sequential wrap", mk(4'h1,1,5), 64'd1, 64'd0, 0, 16'd9, 32'hFFFF_FFFF, 0,0,0,0);
        run("R9 ja always", mk(4'h0,0,5), 64'd1, 64'd2, 0, 16'd7, 32'd20, 1,0,0,0);
    endtask

    task automatic t_call_exit();
        run("R10 call", mk(4'h8,0,5), 64'd0, 64'd0, 32'd3, 16'd0, 32'd50, 0,1,0,0);
        run("R10 exit", mk(4'h9,0,5), 64'd0, 64'd0, 0, 16'd0, 32'd60, 0,0,1,0);
    endtask

    task automatic t_illegal();
        run("R11 ja narrow", mk(4'h0,0,6), 64'd0, 64'd0, 0, 16'd4, 32'd70, 0,0,0,1);
        run("R11 exit narrow", mk(4'h9,0,6), 64'd0, 64'd0, 0, 16'd4, 32'd70, 0,0,0,1);
        run("R11 code e", mk(4'he,1,5), 64'd0, 64'd0, 0, 16'd4, 32'd70, 0,0,0,1);
        run("R11 wrong class", mk(4'h1,1,4), 64'd0, 64'd0, 0, 16'd4, 32'd70, 0,0,0,1);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        opcode = mk(4'h1,1,5); dst_val = 64'd1; src_val = 64'd1; offset = 16'd2; pc = 32'd200;
        issue_valid = 1'b1;
        @(negedge clk);
        check("R2 first of pair", {res_valid, taken, 3'b000, next_pc}, {2'b11, 3'b000, 32'd203});
        opcode = mk(4'h8,0,5); pc = 32'd300;
        @(negedge clk);
        issue_valid = 1'b0;
        check("R2 second of pair", {res_valid, taken, call_pulse, 2'b00, next_pc}, {3'b101, 2'b00, 32'd301});
        @(negedge clk);
        check("R2 R12 idle after pair", {res_valid, taken, call_pulse, exit_pulse, illegal, 32'd0}, 37'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_equality();
        t_operand_select();
        t_unsigned();
        t_signed();
        t_target();
        t_call_exit();
        t_illegal();
        t_back_to_back();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule